// File: doc/BRIEF.md
# Calendar Counter with Posted-Write Busy Flags

This block keeps wall-clock time and calendar date as two packed words that advance once per one-second tick. Seconds, minutes and hours roll over at 60, 60 and 24. The day of the month rolls over at the length of the current month, and February runs to 29 days when the leap flag is set. Years are counted from 1970 in a 6-bit field. The last representable instant is 2033-12-31 23:59:59, and the next tick after it wraps the date back to 1970-01-01.

Software changes the time or the date by posting a write. The write is not applied at once. A commit state machine holds the written word for `COMMIT_CYCLES` clock cycles, which models the transfer into a slow always-on domain, and then loads it into the counter. During that window a busy bit in the status word stays set: bit 8 for a time write and bit 7 for a date write. Any write that arrives while a busy bit is set is dropped. Software polls the status word until bits 9:7 are clear before it posts the next write. Because the time and date words are read separately, two reads can straddle a tick and come from different seconds.

The commit machine has three states. `ST_IDLE` moves to `ST_WAIT_TIME` or `ST_WAIT_DATE` when it accepts a write. Each wait state returns to `ST_IDLE` on its commit transition, when its countdown reaches zero.

Top module: `cal_clock_top`

## Requirements
- R1: After reset the time word reads 0 (00:00:00), the date word reads 0x00000101 (day 1, month 1, year offset 0, leap 0), and the status word reads 0.
- R2: The time word packs seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. Every other bit reads 0. A time write (wr_sel=0) becomes visible exactly COMMIT_CYCLES clock edges after the edge that accepted it.
- R3: The date word packs day in bits 4:0, month in bits 11:8, year offset in bits 21:16 and the leap flag in bit 22. Every other bit reads 0. A date write (wr_sel=1) keeps the leap flag exactly as written.
- R4: Status bit 8 is set from the edge that accepts a time write up to its commit edge. Status bit 7 does the same for a date write. Bit 9 and all other status bits read 0.
- R5: A write presented while any busy bit is set is ignored. It sets no busy bit and changes neither word.
- R6: On a tick, seconds advance, wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R7: On a day carry, day 30 of April, June, September or November and day 31 of any other month other than February go to day 1 of the next month. Any other day increments.
- R8: In February the last day is 29 when the leap flag is 1 and 28 when it is 0.
- R9: A day carry on December 31 sets January 1 of the next year. The leap flag is then recomputed as 1 exactly when (year offset + 1970) is divisible by 4.
- R10: A day carry on 2033-12-31 (year offset 63) wraps the date to 0x00000101 with the leap flag at 0.
- R11: A tick on the same edge as a commit is dropped, and the committed word is loaded unchanged. A tick during the busy window before the commit edge advances the old value as usual.
- R12: With no tick and no commit, both words hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Post a write this cycle |
| wr_sel | input | 1 | Write target: 0 = time word, 1 = date word |
| wr_data | input | 32 | Packed word to write |
| time_word | output | 32 | Current packed time |
| date_word | output | 32 | Current packed date |
| status_word | output | 32 | Busy flags: bit 8 time, bit 7 date, bit 9 reads 0 |

## Verification
The bench builds the block with COMMIT_CYCLES set to 5. This makes the busy window short enough to check edge by edge, so the bench can place a tick on the exact commit edge and on an edge inside the window. Posted writes let the bench load boundary instants directly without waiting through real time:
- 23:59:59 on month ends
- both February cases
- the two year turns either side of a leap year
- the final 2033 instant

Each of these is then reached by a single tick.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HOUR_W  = 5;
    localparam int DAY_W   = 5;
    localparam int MON_W   = 4;
    localparam int YEAR_W  = 6;
    localparam int WORD_W  = 32;

    localparam int BUSY_DATE_BIT  = 7;
    localparam int BUSY_TIME_BIT  = 8;
    localparam int BUSY_ALARM_BIT = 9;

    localparam logic [YEAR_W-1:0] YEAR_LAST = {YEAR_W{1'b1}};

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_TIME = 2'd1,
        ST_WAIT_DATE = 2'd2
    } cmt_state_e;

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } clock_t;

    typedef struct packed {
        logic              leap;
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  month;
        logic [DAY_W-1:0]  day;
    } cal_t;

    function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] m,
                                                    input logic lp);
        logic [DAY_W-1:0] r;
        unique case (m)
            4'd2:                    r = lp ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: r = 5'd30;
            default:                 r = 5'd31;
        endcase
        return r;
    endfunction

    // offset y is a leap year when (y + 1970) % 4 == 0, i.e. y % 4 == 2
    function automatic logic leap_of(input logic [YEAR_W-1:0] y);
        return (y[1:0] == 2'd2);
    endfunction

    function automatic clock_t unpack_time(input logic [WORD_W-1:0] w);
        clock_t c;
        c.sec  = w[5:0];
        c.min  = w[13:8];
        c.hour = w[20:16];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_time(input clock_t c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[5:0]   = c.sec;
        w[13:8]  = c.min;
        w[20:16] = c.hour;
        return w;
    endfunction

    function automatic cal_t unpack_date(input logic [WORD_W-1:0] w);
        cal_t d;
        d.day   = w[4:0];
        d.month = w[11:8];
        d.year  = w[21:16];
        d.leap  = w[22];
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] pack_date(input cal_t d);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[4:0]   = d.day;
        w[11:8]  = d.month;
        w[21:16] = d.year;
        w[22]    = d.leap;
        return w;
    endfunction

endpackage

// File: rtl/cal_commit_fsm.sv
module cal_commit_fsm
    import cal_pkg::*;
#(
    parameter int COMMIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_sel,
    output logic accept,
    output logic busy_time,
    output logic busy_date,
    output logic commit_time,
    output logic commit_date
);

    localparam int CW = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(COMMIT_CYCLES - 1);

    cmt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          expire;

    assign expire = (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en) begin
                    state_d = wr_sel ? ST_WAIT_DATE : ST_WAIT_TIME;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_WAIT_TIME, ST_WAIT_DATE: begin
                if (expire) state_d = ST_IDLE;
                else        cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept      = 1'b0;
        busy_time   = 1'b0;
        busy_date   = 1'b0;
        commit_time = 1'b0;
        commit_date = 1'b0;
        unique case (state_q)
            ST_IDLE:      accept = wr_en;
            ST_WAIT_TIME: begin
                busy_time   = 1'b1;
                commit_time = expire;
            end
            ST_WAIT_DATE: begin
                busy_date   = 1'b1;
                commit_date = expire;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cal_time_ctr.sv
module cal_time_ctr
    import cal_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    input  logic   load,
    input  clock_t load_val,
    output clock_t now,
    output logic   day_carry
);

    clock_t q;
    logic   sec_wrap, min_wrap, hour_wrap;

    assign sec_wrap  = (q.sec  >= SEC_W'(59));
    assign min_wrap  = (q.min  >= MIN_W'(59));
    assign hour_wrap = (q.hour >= HOUR_W'(23));
    assign day_carry = adv && sec_wrap && min_wrap && hour_wrap;
    assign now       = q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (adv) begin
            if (!sec_wrap) begin
                q.sec <= q.sec + 1'b1;
            end else begin
                q.sec <= '0;
                if (!min_wrap) begin
                    q.min <= q.min + 1'b1;
                end else begin
                    q.min  <= '0;
                    q.hour <= hour_wrap ? '0 : q.hour + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cal_date_ctr.sv
module cal_date_ctr
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic load,
    input  cal_t load_val,
    output cal_t now
);

    cal_t              q;
    logic              month_end, year_end;
    logic [YEAR_W-1:0] year_nx;

    assign month_end = (q.day >= month_days(q.month, q.leap));
    assign year_end  = (q.month >= MON_W'(12));
    assign year_nx   = (q.year == YEAR_LAST) ? '0 : q.year + 1'b1;
    assign now       = q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.day   <= DAY_W'(1);
            q.month <= MON_W'(1);
            q.year  <= '0;
            q.leap  <= 1'b0;
        end else if (load) begin
            q <= load_val;
        end else if (adv) begin
            if (!month_end) begin
                q.day <= q.day + 1'b1;
            end else begin
                q.day <= DAY_W'(1);
                if (!year_end) begin
                    q.month <= q.month + 1'b1;
                end else begin
                    q.month <= MON_W'(1);
                    q.year  <= year_nx;
                    q.leap  <= leap_of(year_nx);
                end
            end
        end
    end

endmodule

// File: rtl/cal_clock_top.sv
module cal_clock_top
    import cal_pkg::*;
#(
    parameter int COMMIT_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] time_word,
    output logic [31:0] date_word,
    output logic [31:0] status_word
);

    logic        accept, busy_time, busy_date, commit_time, commit_date;
    logic        adv, day_carry;
    logic [31:0] pend_q;
    clock_t      clk_now;
    cal_t        cal_now;

    cal_commit_fsm #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .accept      (accept),
        .busy_time   (busy_time),
        .busy_date   (busy_date),
        .commit_time (commit_time),
        .commit_date (commit_date)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend_q <= '0;
        else if (accept) pend_q <= wr_data;
    end

    // a tick landing on a commit edge is discarded
    assign adv = tick && !(commit_time || commit_date);

    cal_time_ctr u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .load      (commit_time),
        .load_val  (unpack_time(pend_q)),
        .now       (clk_now),
        .day_carry (day_carry)
    );

    cal_date_ctr u_date (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (day_carry),
        .load     (commit_date),
        .load_val (unpack_date(pend_q)),
        .now      (cal_now)
    );

    always_comb begin
        time_word                   = pack_time(clk_now);
        date_word                   = pack_date(cal_now);
        status_word                 = '0;
        status_word[BUSY_TIME_BIT]  = busy_time;
        status_word[BUSY_DATE_BIT]  = busy_date;
        status_word[BUSY_ALARM_BIT] = 1'b0;
    end

endmodule

// File: rtl/cal_clock_checks.sv
module cal_clock_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] time_word,
    input logic [31:0] date_word,
    input logic [31:0] status_word
);

    logic idle;
    assign idle = (status_word[9:7] == 3'b000);

    AST_BUSY_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_word[8:7])); // R4

    AST_TIME_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && wr_en && !wr_sel) |=> status_word[8]); // R4

    AST_DATE_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && wr_en && wr_sel) |=> status_word[7]); // R4

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[8] && wr_en && wr_sel) |=> !status_word[7]); // R5

    AST_TIME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !status_word[8]) |=> $stable(time_word)); // R12

    AST_DATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !status_word[7]) |=> $stable(date_word)); // R12

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && idle && time_word[5:0] == 6'd59) |=> (time_word[5:0] == 6'd0)); // R6

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && idle && time_word[5:0] < 6'd59)
        |=> (time_word[5:0] == $past(time_word[5:0]) + 6'd1)); // R6

endmodule

bind cal_clock_top cal_clock_checks u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .time_word   (time_word),
    .date_word   (date_word),
    .status_word (status_word)
);

// File: tb/cal_clock_top_test.sv
module cal_clock_top_test;

    localparam int C = 5;
    localparam int NV = 12;

    // {time in, date in, expected time, expected date} after one tick
    localparam logic [31:0] VEC [NV][4] = '{
        '{32'h000A141E, 32'h0005040A, 32'h000A141F, 32'h0005040A}, // R6 second step
        '{32'h000A143B, 32'h0005040A, 32'h000A1500, 32'h0005040A}, // R6 minute carry
        '{32'h000A3B3B, 32'h0005040A, 32'h000B0000, 32'h0005040A}, // R6 hour carry
        '{32'h00173B3B, 32'h0005041E, 32'h00000000, 32'h00050501}, // R7 April 30
        '{32'h00173B3B, 32'h0005051E, 32'h00000000, 32'h0005051F}, // R7 May 30
        '{32'h00173B3B, 32'h00050B1E, 32'h00000000, 32'h00050C01}, // R7 Nov 30
        '{32'h00173B3B, 32'h0042021C, 32'h00000000, 32'h0042021D}, // R8 leap Feb 28
        '{32'h00173B3B, 32'h0003021C, 32'h00000000, 32'h00030301}, // R8 plain Feb 28
        '{32'h00173B3B, 32'h0042021D, 32'h00000000, 32'h00420301}, // R8 leap Feb 29
        '{32'h00173B3B, 32'h00010C1F, 32'h00000000, 32'h00420101}, // R9 into leap year
        '{32'h00173B3B, 32'h00420C1F, 32'h00000000, 32'h00030101}, // R9 out of leap year
        '{32'h00173B3B, 32'h003F0C1F, 32'h00000000, 32'h00000101}  // R10 final wrap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] time_word, date_word, status_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cal_clock_top #(.COMMIT_CYCLES(C)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .time_word(time_word), .date_word(date_word),
        .status_word(status_word)
    );

    function automatic string vec_tag(input int k);
        if (k < 3)       return "R6";
        else if (k < 6)  return "R7";
        else if (k < 9)  return "R8";
        else if (k < 11) return "R9";
        else             return "R10";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // accept edge falls between the two negedges; returns just after it
    task automatic post(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic post_and_wait(input logic sel, input logic [31:0] d);
        post(sel, d);
        repeat (C) @(negedge clk);
    endtask

    task automatic pulse_tick;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 time", time_word, 32'h0);
        check("R1 date", date_word, 32'h00000101);
        check("R1 status", status_word, 32'h0);

        // vector table
        for (int k = 0; k < NV; k++) begin
            post_and_wait(1'b0, VEC[k][0]);
            post_and_wait(1'b1, VEC[k][1]);
            pulse_tick();
            check({vec_tag(k), " time"}, time_word, VEC[k][2]);
            check({vec_tag(k), " date"}, date_word, VEC[k][3]);
        end

        // R2 / R4: commit timing and busy window for a time write
        post(1'b0, 32'h00050607);
        check("R4 time busy set", status_word, 32'h00000100);
        repeat (C - 1) @(negedge clk);
        check("R2 not yet committed", time_word, 32'h0);
        check("R4 still busy", status_word, 32'h00000100);
        @(negedge clk);
        check("R2 committed", time_word, 32'h00050607);
        check("R4 busy cleared", status_word, 32'h0);

        // R2: unused time bits discarded
        post_and_wait(1'b0, 32'hFFFFFFFF);
        check("R2 unused bits", time_word, 32'h001F3F3F);

        // R3 / R4: date write, leap kept as written, busy bit 7
        post(1'b1, 32'hFFFFFFFF);
        check("R4 date busy set", status_word, 32'h00000080);
        repeat (C) @(negedge clk);
        check("R3 packing", date_word, 32'h007F0F1F);
        post_and_wait(1'b1, 32'h00430305);
        check("R3 leap as written", date_word, 32'h00430305);

        // R5: date write during time busy is dropped
        post(1'b0, 32'h00010203);
        post(1'b1, 32'h00090909);
        check("R5 no date busy", status_word, 32'h00000100);
        repeat (C) @(negedge clk);
        check("R5 date unchanged", date_word, 32'h00430305);
        check("R5 status idle", status_word, 32'h0);

        // R11: tick on the commit edge is dropped
        post(1'b0, 32'h00020304);
        repeat (C - 1) @(negedge clk);
        pulse_tick();
        check("R11 commit edge tick dropped", time_word, 32'h00020304);

        // R11: tick inside busy window advances old value
        post(1'b0, 32'h00111111);
        pulse_tick();
        check("R11 tick while busy", time_word, 32'h00020305);
        repeat (C - 1) @(negedge clk);
        check("R11 later commit", time_word, 32'h00111111);

        // R12: no tick, values hold
        repeat (20) @(negedge clk);
        check("R12 time holds", time_word, 32'h00111111);
        check("R12 date holds", date_word, 32'h00430305);

        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 50000 && !done; n++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule